// File: doc/BRIEF.md
# Link Frame Decoder and Classifier

This block sits behind a byte-wide receive port of a network transceiver. The port drives a data-valid strobe. While the strobe is high, the block hunts for a fixed two-byte start pattern, reads a four-byte frame header and sorts the payload by the header's type code. Display packets and control packets share the link in time. Pixel bytes leave on a streaming output with first and last markers. Control bytes fill a bank of scan-setting registers that the display output reads.

The start pattern has two parts that must arrive in this order: a marker byte `H_CODE` (default 0xA5), then a delimiter byte `SSD_CODE` (default 0xD5). Any other byte arriving where the delimiter is due is a framing error. A framing error, or the strobe falling before the header is complete, discards the frame and advances a saturating error counter.

Settings from a control frame are built in a shadow copy. They become visible only when the last payload byte arrives, so the scan logic never sees a half-written configuration.

Top module: `lnk_frame_demux`

## Requirements
- R1: After reset, `cfg_flat` is all zero, `err_cnt` is zero, and `pix_valid`, `pix_sof`, `pix_eof` and `cfg_commit` are low.
- R2: A frame is accepted only after `H_CODE` and then `SSD_CODE` are received as consecutive valid bytes. Valid bytes other than `H_CODE` that come before the marker are ignored.
- R3: If a valid byte other than `SSD_CODE` directly follows the marker, `err_cnt` increases by one. No output is driven for any byte up to the next low cycle of `rx_dv`.
- R4: If `rx_dv` goes low after the first valid byte but before the fourth header byte, `err_cnt` increases by one and nothing is output.
- R5: The header has four bytes in this order: type, payload length high byte, payload length low byte, reserved. Type 0x02 marks pixel data. Each pixel payload byte appears on `pix_data` with `pix_valid` high in the cycle after it is sampled. `pix_sof` marks payload byte 0 and `pix_eof` marks the byte at index length-1.
- R6: Type 0x01 marks control. Control payload byte k goes to register k, which is `cfg_flat[8k+7:8k]`. Bytes with k >= `NREG` are dropped. Registers that the frame does not reach keep their previous committed values.
- R7: `cfg_flat` changes only in the cycle after the last control payload byte is sampled. That last byte is part of the update, and `cfg_commit` is high for exactly that one cycle.
- R8: If `rx_dv` drops during a control payload, `cfg_flat` stays unchanged, `cfg_commit` stays low and `err_cnt` does not change.
- R9: A type code other than 0x01 or 0x02, or a length field of zero, causes the frame to be skipped. No output is driven and `err_cnt` does not change.
- R10: Valid bytes after the declared payload length are ignored until `rx_dv` goes low, even if they contain the start pattern.
- R11: `err_cnt` never wraps. It holds at 2^`ERR_W`-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_dv | input | 1 | Receive byte valid strobe |
| rx_byte | input | 8 | Receive byte |
| cfg_flat | output | NREG*8 | Committed scan-setting registers; register k is at bits 8k+7:8k |
| cfg_commit | output | 1 | One-cycle pulse when a control frame is committed |
| pix_valid | output | 1 | Pixel byte valid |
| pix_data | output | 8 | Pixel byte |
| pix_sof | output | 1 | First payload byte of a pixel frame |
| pix_eof | output | 1 | Last payload byte of a pixel frame |
| err_cnt | output | ERR_W | Saturating framing-error count |

## Verification
Two things happen in the same clock edge: the final control byte is written, and the commit of the whole bank. A single-cycle design must forward that byte into the committed copy, not publish a shadow copy that is one write behind. The bench makes this happen with directed and random control frames whose last byte lands on a register, and with frames longer than the bank, where the last byte lands on no register. It samples `cfg_commit` in the cycle right after that byte and compares `cfg_flat` to a bench-side register model. The same model checks that registers the frame does not reach keep their earlier values.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

  localparam int LEN_W = 16;

  localparam logic [7:0] TYPE_CTRL = 8'h01;
  localparam logic [7:0] TYPE_DATA = 8'h02;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_H,
    ST_WAIT_SSD,
    ST_HDR,
    ST_PCTRL,
    ST_PDATA,
    ST_SKIP
  } lnk_st_e;

  typedef enum logic [1:0] {
    K_CTRL,
    K_DATA,
    K_OTHER
  } lnk_kind_e;

  // Payload length from the two header bytes, high byte first.
  function automatic logic [LEN_W-1:0] f_len(input logic [7:0] hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction

  function automatic lnk_kind_e f_kind(input logic [7:0] t);
    if (t == TYPE_CTRL) return K_CTRL;
    if (t == TYPE_DATA) return K_DATA;
    return K_OTHER;
  endfunction

  // Saturating increment on a counter whose ceiling is maxv.
  function automatic int unsigned f_sat_next(input int unsigned cur, input int unsigned maxv);
    return (cur >= maxv) ? maxv : cur + 1;
  endfunction

endpackage

// File: rtl/lnk_rx_fsm.sv
module lnk_rx_fsm
  import lnk_pkg::*;
#(
  parameter logic [7:0] H_CODE   = 8'hA5,
  parameter logic [7:0] SSD_CODE = 8'hD5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_dv,
  input  logic [7:0]       rx_byte,
  output logic             ev_err,
  output logic             ctrl_open,
  output logic             ctrl_wr,
  output logic             ctrl_last,
  output logic             pix_go,
  output logic             pix_first,
  output logic             pix_last,
  output logic [LEN_W-1:0] wr_idx,
  output logic [7:0]       wr_byte
);

  localparam int HDR_BYTES = 4;
  localparam int HIDX_W    = $clog2(HDR_BYTES);

  lnk_st_e            st, nxt;
  logic [HIDX_W-1:0]  hidx;
  logic [7:0]         type_q, len_hi_q, len_lo_q;
  logic [LEN_W-1:0]   pcnt;
  logic [LEN_W-1:0]   len_full;
  logic               pay_end;

  assign len_full = f_len(len_hi_q, len_lo_q);
  assign pay_end  = (pcnt == len_full - 1'b1);
  assign wr_idx   = pcnt;
  assign wr_byte  = rx_byte;

  always_comb begin
    nxt       = st;
    ev_err    = 1'b0;
    ctrl_open = 1'b0;
    ctrl_wr   = 1'b0;
    ctrl_last = 1'b0;
    pix_go    = 1'b0;
    pix_first = 1'b0;
    pix_last  = 1'b0;
    case (st)
      ST_IDLE: begin
        if (rx_dv) nxt = (rx_byte == H_CODE) ? ST_WAIT_SSD : ST_WAIT_H;
      end
      ST_WAIT_H: begin
        if (!rx_dv) begin
          nxt    = ST_IDLE;
          ev_err = 1'b1;
        end else if (rx_byte == H_CODE) begin
          nxt = ST_WAIT_SSD;
        end
      end
      ST_WAIT_SSD: begin
        if (!rx_dv) begin
          nxt    = ST_IDLE;
          ev_err = 1'b1;
        end else if (rx_byte == SSD_CODE) begin
          nxt = ST_HDR;
        end else begin
          nxt    = ST_SKIP;
          ev_err = 1'b1;
        end
      end
      ST_HDR: begin
        if (!rx_dv) begin
          nxt    = ST_IDLE;
          ev_err = 1'b1;
        end else if (hidx == HIDX_W'(HDR_BYTES - 1)) begin
          if (len_full == '0) begin
            nxt = ST_SKIP;
          end else begin
            case (f_kind(type_q))
              K_CTRL: begin
                nxt       = ST_PCTRL;
                ctrl_open = 1'b1;
              end
              K_DATA:  nxt = ST_PDATA;
              default: nxt = ST_SKIP;
            endcase
          end
        end
      end
      ST_PCTRL: begin
        if (!rx_dv) begin
          nxt = ST_IDLE;
        end else begin
          ctrl_wr   = 1'b1;
          ctrl_last = pay_end;
          if (pay_end) nxt = ST_SKIP;
        end
      end
      ST_PDATA: begin
        if (!rx_dv) begin
          nxt = ST_IDLE;
        end else begin
          pix_go    = 1'b1;
          pix_first = (pcnt == '0);
          pix_last  = pay_end;
          if (pay_end) nxt = ST_SKIP;
        end
      end
      ST_SKIP: begin
        if (!rx_dv) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hidx     <= '0;
      type_q   <= '0;
      len_hi_q <= '0;
      len_lo_q <= '0;
    end else if (st == ST_WAIT_SSD) begin
      hidx <= '0;
    end else if (st == ST_HDR && rx_dv) begin
      hidx <= hidx + 1'b1;
      case (hidx)
        HIDX_W'(0): type_q   <= rx_byte;
        HIDX_W'(1): len_hi_q <= rx_byte;
        HIDX_W'(2): len_lo_q <= rx_byte;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (st == ST_HDR) begin
      pcnt <= '0;
    end else if ((st == ST_PCTRL || st == ST_PDATA) && rx_dv) begin
      pcnt <= pcnt + 1'b1;
    end
  end

endmodule

// File: rtl/lnk_cfg_bank.sv
module lnk_cfg_bank
  import lnk_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_frm,
  input  logic              wr,
  input  logic              last,
  input  logic [LEN_W-1:0]  idx,
  input  logic [7:0]        wbyte,
  output logic [NREG*8-1:0] cfg_flat,
  output logic              commit
);

  logic commit_now;
  assign commit_now = wr && last;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [7:0] shd;
    logic [7:0] act;
    logic       hit;

    assign hit = wr && (idx == LEN_W'(i));

    // Shadow starts each control frame as a copy of the committed value.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        shd <= '0;
      else if (open_frm) shd <= act;
      else if (hit)      shd <= wbyte;
    end

    // Commit forwards the byte written in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          act <= '0;
      else if (commit_now) act <= hit ? wbyte : shd;
    end

    assign cfg_flat[8*i +: 8] = act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) commit <= 1'b0;
    else        commit <= commit_now;
  end

endmodule

// File: rtl/lnk_pix_stage.sv
module lnk_pix_stage (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       first,
  input  logic       last,
  input  logic [7:0] din,
  output logic       pix_valid,
  output logic [7:0] pix_data,
  output logic       pix_sof,
  output logic       pix_eof
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix_sof   <= 1'b0;
      pix_eof   <= 1'b0;
    end else begin
      pix_valid <= go;
      pix_sof   <= go && first;
      pix_eof   <= go && last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  pix_data <= '0;
    else if (go) pix_data <= din;
  end

endmodule

// File: rtl/lnk_err_ctr.sv
module lnk_err_ctr
  import lnk_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [ERR_W-1:0] cnt
);

  localparam int unsigned ERR_MAX = (1 << ERR_W) - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (bump) cnt <= ERR_W'(f_sat_next(32'(cnt), ERR_MAX));
  end

endmodule

// File: rtl/lnk_frame_demux.sv
module lnk_frame_demux
  import lnk_pkg::*;
#(
  parameter logic [7:0] H_CODE   = 8'hA5,
  parameter logic [7:0] SSD_CODE = 8'hD5,
  parameter int         NREG     = 8,
  parameter int         ERR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_dv,
  input  logic [7:0]        rx_byte,
  output logic [NREG*8-1:0] cfg_flat,
  output logic              cfg_commit,
  output logic              pix_valid,
  output logic [7:0]        pix_data,
  output logic              pix_sof,
  output logic              pix_eof,
  output logic [ERR_W-1:0]  err_cnt
);

  // Internal events, named for the checker.
  logic             ev_err;
  logic             ctrl_open;
  logic             ctrl_wr;
  logic             ctrl_last;
  logic             pix_go;
  logic             pix_first;
  logic             pix_last;
  logic [LEN_W-1:0] wr_idx;
  logic [7:0]       wr_byte;

  lnk_rx_fsm #(
    .H_CODE   (H_CODE),
    .SSD_CODE (SSD_CODE)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_dv     (rx_dv),
    .rx_byte   (rx_byte),
    .ev_err    (ev_err),
    .ctrl_open (ctrl_open),
    .ctrl_wr   (ctrl_wr),
    .ctrl_last (ctrl_last),
    .pix_go    (pix_go),
    .pix_first (pix_first),
    .pix_last  (pix_last),
    .wr_idx    (wr_idx),
    .wr_byte   (wr_byte)
  );

  lnk_cfg_bank #(
    .NREG (NREG)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .open_frm (ctrl_open),
    .wr       (ctrl_wr),
    .last     (ctrl_last),
    .idx      (wr_idx),
    .wbyte    (wr_byte),
    .cfg_flat (cfg_flat),
    .commit   (cfg_commit)
  );

  lnk_pix_stage u_pix (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (pix_go),
    .first     (pix_first),
    .last      (pix_last),
    .din       (wr_byte),
    .pix_valid (pix_valid),
    .pix_data  (pix_data),
    .pix_sof   (pix_sof),
    .pix_eof   (pix_eof)
  );

  lnk_err_ctr #(
    .ERR_W (ERR_W)
  ) u_err (
    .clk  (clk),
    .rst_n(rst_n),
    .bump (ev_err),
    .cnt  (err_cnt)
  );

endmodule

// File: rtl/lnk_frame_demux_chk.sv
module lnk_frame_demux_chk #(
  parameter int NREG  = 8,
  parameter int ERR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_dv,
  input logic [NREG*8-1:0] cfg_flat,
  input logic              cfg_commit,
  input logic              pix_valid,
  input logic              pix_sof,
  input logic              pix_eof,
  input logic [ERR_W-1:0]  err_cnt,
  input logic              ev_err,
  input logic              ctrl_wr,
  input logic              ctrl_last
);

  localparam logic [ERR_W-1:0] ERR_TOP = '1;

  AST_PIX_NEEDS_DV: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(rx_dv)); // R5

  AST_MARKS_IN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_sof || pix_eof) |-> pix_valid); // R5

  AST_CFG_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_flat != $past(cfg_flat)) |-> cfg_commit); // R7

  AST_COMMIT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_commit |-> $past(ctrl_wr && ctrl_last)); // R7

  AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_commit |=> !cfg_commit); // R7

  AST_PATHS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_valid && cfg_commit)); // R6

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt != $past(err_cnt)) |-> $past(ev_err)); // R4

  AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt != $past(err_cnt)) |-> (err_cnt == $past(err_cnt) + 1'b1)); // R11

  AST_ERR_HOLD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt == ERR_TOP) |=> (err_cnt == ERR_TOP)); // R11

endmodule

bind lnk_frame_demux lnk_frame_demux_chk #(
  .NREG  (NREG),
  .ERR_W (ERR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_dv      (rx_dv),
  .cfg_flat   (cfg_flat),
  .cfg_commit (cfg_commit),
  .pix_valid  (pix_valid),
  .pix_sof    (pix_sof),
  .pix_eof    (pix_eof),
  .err_cnt    (err_cnt),
  .ev_err     (ev_err),
  .ctrl_wr    (ctrl_wr),
  .ctrl_last  (ctrl_last)
);

// File: tb/tb_lnk_frame_demux.sv
module tb_lnk_frame_demux;

  localparam logic [7:0] HB = 8'hA5;
  localparam logic [7:0] SB = 8'hD5;
  localparam int NR = 8;
  localparam int EW = 8;
  localparam logic [7:0] T_CTRL = 8'h01;
  localparam logic [7:0] T_DATA = 8'h02;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            rx_dv = 1'b0;
  logic [7:0]      rx_byte = 8'h00;
  logic [NR*8-1:0] cfg_flat;
  logic            cfg_commit;
  logic            pix_valid;
  logic [7:0]      pix_data;
  logic            pix_sof;
  logic            pix_eof;
  logic [EW-1:0]   err_cnt;

  always #5 clk = ~clk;

  lnk_frame_demux #(.H_CODE(HB), .SSD_CODE(SB), .NREG(NR), .ERR_W(EW)) dut (
    .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_byte(rx_byte),
    .cfg_flat(cfg_flat), .cfg_commit(cfg_commit),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_sof(pix_sof), .pix_eof(pix_eof),
    .err_cnt(err_cnt)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0] got[$];
  int sof_n, eof_n, com_n, sof_pos, eof_pos;
  logic [7:0] frm[$];
  logic [7:0] pl[$];
  logic [7:0] mdl[NR];
  int exp_err;
  bit probe_hit;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pix_valid) begin
        if (pix_sof) begin sof_n++; sof_pos = got.size(); end
        got.push_back(pix_data);
        if (pix_eof) begin eof_n++; eof_pos = got.size() - 1; end
      end
      if (cfg_commit) com_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NR*8-1:0] mdl_flat();
    logic [NR*8-1:0] f;
    for (int k = 0; k < NR; k++) f[8*k +: 8] = mdl[k];
    return f;
  endfunction

  // Bench view of a committed control frame: bytes land by index, the rest stay.
  function automatic void mdl_apply(input int len);
    for (int k = 0; k < len; k++) if (k < NR) mdl[k] = pl[k];
  endfunction

  function automatic logic [7:0] fill_byte();
    logic [7:0] b;
    b = 8'($urandom);
    if (b == HB) b = b ^ 8'h01;
    return b;
  endfunction

  function automatic void mk(input int nfill, input logic [7:0] typ, input int lenf,
                             input int nsent, input int ntail);
    frm.delete();
    for (int k = 0; k < nfill; k++) frm.push_back(fill_byte());
    frm.push_back(HB);
    frm.push_back(SB);
    frm.push_back(typ);
    frm.push_back(8'(lenf >> 8));
    frm.push_back(8'(lenf));
    frm.push_back(8'h00);
    for (int k = 0; k < nsent; k++) frm.push_back(pl[k]);
    for (int k = 0; k < ntail; k++) frm.push_back(8'($urandom));
  endfunction

  function automatic void mk_pl(input int n);
    pl.delete();
    for (int k = 0; k < n; k++) pl.push_back(8'($urandom));
  endfunction

  task automatic clr();
    got.delete();
    sof_n = 0; eof_n = 0; com_n = 0; sof_pos = -1; eof_pos = -1;
  endtask

  // Drive the frame; probe samples cfg_commit in the cycle after byte 'probe'.
  task automatic play(input int probe);
    probe_hit = 1'b0;
    for (int i = 0; i < frm.size(); i++) begin
      @(negedge clk);
      if (probe >= 0 && i == probe + 1) probe_hit = cfg_commit;
      rx_dv = 1'b1;
      rx_byte = frm[i];
    end
    @(negedge clk);
    if (probe >= 0 && probe == frm.size() - 1) probe_hit = cfg_commit;
    rx_dv = 1'b0;
    rx_byte = 8'h00;
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_data(input string tag, input int nexp, input bit full);
    chk(got.size() == nexp, {tag, " count"}, got.size(), nexp);
    for (int k = 0; k < nexp && k < got.size(); k++)
      chk(got[k] == pl[k], {tag, " byte"}, got[k], pl[k]);
    if (nexp > 0) chk(sof_n == 1 && sof_pos == 0, {tag, " sof"}, sof_n, 1);
    chk(eof_n == (full ? 1 : 0), {tag, " eof"}, eof_n, full);
    if (full) chk(eof_pos == nexp - 1, {tag, " eof pos"}, eof_pos, nexp - 1);
  endtask

  task automatic chk_quiet(input string tag);
    chk(got.size() == 0, {tag, " no pixels"}, got.size(), 0);
    chk(com_n == 0, {tag, " no commit"}, com_n, 0);
    chk(cfg_flat == mdl_flat(), {tag, " cfg kept"}, cfg_flat, mdl_flat());
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    for (int k = 0; k < NR; k++) mdl[k] = 8'h00;
    exp_err = 0;
    clr();
    repeat (3) @(negedge clk);
    chk(cfg_flat == '0, "R1 cfg reset", cfg_flat, 0);
    chk(err_cnt == 0, "R1 err reset", err_cnt, 0);
    chk(!pix_valid && !pix_sof && !pix_eof && !cfg_commit, "R1 strobes reset",
        {pix_valid, pix_sof, pix_eof, cfg_commit}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R5: leading filler, then a pixel frame
    clr(); mk_pl(5); mk(3, T_DATA, 5, 5, 0); play(-1);
    chk_data("R2 R5 data after filler", 5, 1);
    chk(err_cnt == 0, "R2 no error", err_cnt, 0);

    // R6 R7: short control frame, commit timing
    clr(); mk_pl(3); mk(0, T_CTRL, 3, 3, 0); play(6 + 2);
    mdl_apply(3);
    chk(probe_hit == 1'b1, "R7 commit right after last byte", probe_hit, 1);
    chk(com_n == 1, "R7 single commit", com_n, 1);
    chk(cfg_flat == mdl_flat(), "R6 regs 0..2", cfg_flat, mdl_flat());

    // R6 R7: control frame longer than the bank, last byte lands nowhere
    clr(); mk_pl(NR + 2); mk(1, T_CTRL, NR + 2, NR + 2, 0); play(1 + 6 + NR + 1);
    mdl_apply(NR + 2);
    chk(probe_hit == 1'b1, "R7 commit on overlong frame", probe_hit, 1);
    chk(cfg_flat == mdl_flat(), "R6 overlong bytes dropped", cfg_flat, mdl_flat());

    // R8: truncated control frame
    clr(); mk_pl(6); mk(0, T_CTRL, 6, 3, 0); play(-1);
    chk_quiet("R8 truncated ctrl");
    chk(err_cnt == exp_err, "R8 err unchanged", err_cnt, exp_err);

    // R3: wrong byte after marker, then a valid-looking tail
    clr(); frm.delete(); frm.push_back(HB); frm.push_back(8'h33);
    frm.push_back(HB); frm.push_back(SB); frm.push_back(T_DATA);
    frm.push_back(8'h00); frm.push_back(8'h02); frm.push_back(8'h00);
    frm.push_back(8'h11); frm.push_back(8'h22);
    play(-1); exp_err++;
    chk(err_cnt == exp_err, "R3 bad delimiter counted", err_cnt, exp_err);
    chk_quiet("R3 rest ignored");

    // R4: strobe drops while hunting, after marker, inside header
    clr(); frm.delete(); frm.push_back(8'h10); play(-1); exp_err++;
    chk(err_cnt == exp_err, "R4 drop before marker", err_cnt, exp_err);
    clr(); frm.delete(); frm.push_back(HB); play(-1); exp_err++;
    chk(err_cnt == exp_err, "R4 drop after marker", err_cnt, exp_err);
    clr(); frm.delete(); frm.push_back(HB); frm.push_back(SB);
    frm.push_back(T_DATA); frm.push_back(8'h00); frm.push_back(8'h04); play(-1); exp_err++;
    chk(err_cnt == exp_err, "R4 drop in header", err_cnt, exp_err);
    chk_quiet("R4 no output");

    // R9: unknown type and zero length
    clr(); mk_pl(4); mk(0, 8'h07, 4, 4, 0); play(-1);
    chk_quiet("R9 unknown type");
    chk(err_cnt == exp_err, "R9 err unchanged", err_cnt, exp_err);
    clr(); mk_pl(3); mk(0, T_DATA, 0, 3, 0); play(-1);
    chk_quiet("R9 zero length");

    // R10: tail after declared length contains a start pattern
    clr(); mk_pl(3); mk(0, T_DATA, 3, 3, 0);
    frm.push_back(HB); frm.push_back(SB); frm.push_back(T_DATA);
    frm.push_back(8'h00); frm.push_back(8'h01); frm.push_back(8'h00); frm.push_back(8'h99);
    play(-1);
    chk_data("R10 tail ignored", 3, 1);

    // Random mix of control and pixel frames
    for (int it = 0; it < 40; it++) begin
      logic [7:0] typ;
      int len, nsent, ntail, nfill;
      bit trunc;
      typ   = ($urandom % 2) ? T_CTRL : T_DATA;
      len   = 1 + ($urandom % 12);
      trunc = (($urandom % 4) == 0);
      nsent = trunc ? ($urandom % len) : len;
      ntail = trunc ? 0 : ($urandom % 3);
      nfill = $urandom % 3;
      clr(); mk_pl(len); mk(nfill, typ, len, nsent, ntail);
      play((typ == T_CTRL && !trunc) ? nfill + 6 + len - 1 : -1);
      if (typ == T_CTRL) begin
        if (!trunc) begin
          mdl_apply(len);
          chk(probe_hit == 1'b1, "R7 random commit timing", probe_hit, 1);
        end
        chk(com_n == (trunc ? 0 : 1), "R7 R8 random commit count", com_n, !trunc);
        chk(cfg_flat == mdl_flat(), "R6 random cfg", cfg_flat, mdl_flat());
        chk(got.size() == 0, "R6 ctrl not on pixel path", got.size(), 0);
      end else begin
        chk_data("R5 random data", nsent, !trunc);
        chk(com_n == 0, "R5 data no commit", com_n, 0);
      end
      chk(err_cnt == exp_err, "R2 random err stable", err_cnt, exp_err);
    end

    // R11: saturation
    for (int i = 0; i < 260; i++) begin
      frm.delete(); frm.push_back(8'h00); play(-1);
    end
    chk(err_cnt == {EW{1'b1}}, "R11 saturate", err_cnt, {EW{1'b1}});

    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule